// File: doc/BRIEF.md
# Loopback Bit-Error-Test Symbol Handler

This block sits between the receive decoder and the transmit encoder of a serial link that is held in loopback. Each clock it may take one decoded symbol: an 8-bit value, a flag marking it as a control character, a flag marking a decode failure, and a valid strobe. It echoes the symbol to the transmit side one cycle later. It also watches the stream for three in-band sequences that drive a built-in bit-error test. A clear sequence zeroes the error total and starts the test. Test data is then compared against a locally generated descrambler keystream. A count request makes the transmit side send a report that carries the error total.

A test instrument uses the block as follows. It sends the clear pair, then scrambled all-zero payload for as long as the test requires, then a repeating request character. It decodes the report that comes back on the loopback transmit path. The block has no other access path: the counter is zeroed, fed and read entirely through the symbol stream.

Top module: `bert_loopback`

## Requirements
- R1: A synchronous active-high reset drives tx_valid, tx_data and tx_ctrl to zero and the error total to zero, with counting disabled.
- R2: Every valid input symbol that does not fall in a report slot (R8) appears on tx_data/tx_ctrl one clock later with tx_valid high, unchanged.
- R3: Two consecutive valid control symbols 0xBC then 0xFC zero the error total and enable counting. A 0xFC that is not directly preceded by 0xBC has no effect on the total.
- R4: A valid control 0xBC reloads the 16-bit keystream register with 0xFFFF. Each data symbol takes a keystream byte whose bit i (i = 0 first) is register bit 15. After each bit the register shifts left by one, and if the bit shifted out was 1 it is XORed with 0x0039 (x^16+x^5+x^4+x^3+1). The register advances by 8 such steps per data symbol.
- R5: Once counting is enabled, a data symbol adds one to the total when its value XOR the keystream byte is non-zero or its decode-error flag is set. A matching, error-free symbol adds nothing.
- R6: Before the first clear pair after reset, data symbols never change the total.
- R7: The 8-bit total saturates at 255 and never wraps.
- R8: A valid control 0x7C outside a report slot is echoed as control 0x7C. The next valid symbol slot is a report slot: the transmit side carries a data symbol equal to the current total. The symbol received in that slot is neither echoed, counted, nor used to advance the keystream. A repeating 0x7C stream therefore yields alternating 0x7C and total.
- R9: After a report, data symbols are counted again and the keystream continues from where it stopped.
- R10: A cycle with rx_valid low changes no state: tx_valid is low in the next cycle and the total is unchanged.
- R11: Control symbols (other than the 0xBC reload) do not advance the keystream and are never counted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Symbol clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Receive symbol strobe |
| rx_data | input | 8 | Decoded receive symbol value |
| rx_ctrl | input | 1 | Receive symbol is a control character |
| rx_err | input | 1 | Receive symbol failed decoding |
| tx_valid | output | 1 | Transmit symbol strobe |
| tx_data | output | 8 | Transmit symbol value |
| tx_ctrl | output | 1 | Transmit symbol is a control character |

## Verification
The bench builds the block with its default parameters: 8-bit symbols, an 8-bit total and a 16-bit keystream register. These sizes are small enough to sweep every one of the 256 possible corruption masks against the keystream in one run, so the total lands exactly on 255 from below. A further run of 300 errors drives the total past saturation. Every report value is predicted from an independent keystream model in the bench, so miscounting, wrong seeding or a keystream that advances on the wrong symbols all show up as a wrong report byte.

// File: rtl/bert_pkg.sv
package bert_pkg;
  localparam logic [7:0] K_CLR_A = 8'hBC;  // first symbol of clear pair, keystream reload
  localparam logic [7:0] K_CLR_B = 8'hFC;  // second symbol of clear pair
  localparam logic [7:0] K_QUERY = 8'h7C;  // count request / report header

  typedef struct packed {
    logic       ctrl;
    logic [7:0] data;
  } sym_t;
endpackage

// File: rtl/bert_descrambler.sv
module bert_descrambler #(
  parameter int              LFSR_W = 16,
  parameter int              SYM_W  = 8,
  parameter logic [LFSR_W-1:0] TAPS = 16'h0039,
  parameter logic [LFSR_W-1:0] SEED = 16'hFFFF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reload,
  input  logic             advance,
  output logic [SYM_W-1:0] key
);
  logic [LFSR_W-1:0] state_q;
  logic [LFSR_W-1:0] state_nx;

  always_comb begin
    logic [LFSR_W-1:0] s;
    s = state_q;
    for (int i = 0; i < SYM_W; i++) begin
      key[i] = s[LFSR_W-1];
      s = {s[LFSR_W-2:0], 1'b0} ^ (s[LFSR_W-1] ? TAPS : '0);
    end
    state_nx = s;
  end

  always_ff @(posedge clk) begin
    if (rst)          state_q <= SEED;
    else if (reload)  state_q <= SEED;
    else if (advance) state_q <= state_nx;
  end
endmodule

// File: rtl/bert_os_detect.sv
module bert_os_detect
  import bert_pkg::*;
#(
  parameter int SYM_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             valid,
  input  logic [SYM_W-1:0] data,
  input  logic             ctrl,
  output logic             reload,
  output logic             clear,
  output logic             query,
  output logic             slot,
  output logic             armed
);
  logic prev_a_q;
  logic slot_q;
  logic armed_q;
  logic live;

  assign live   = valid && !slot_q;
  assign reload = live && ctrl && (data == SYM_W'(K_CLR_A));
  assign clear  = live && ctrl && (data == SYM_W'(K_CLR_B)) && prev_a_q;
  assign query  = live && ctrl && (data == SYM_W'(K_QUERY));
  assign slot   = slot_q;
  assign armed  = armed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_a_q <= 1'b0;
      slot_q   <= 1'b0;
      armed_q  <= 1'b0;
    end else if (valid) begin
      prev_a_q <= reload;
      slot_q   <= query;
      armed_q  <= armed_q || clear;
    end
  end
endmodule

// File: rtl/bert_err_counter.sv
module bert_err_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             hit,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk) begin
    if (rst)                          count <= '0;
    else if (clear)                   count <= '0;
    else if (hit && count != CNT_MAX) count <= count + 1'b1;
  end
endmodule

// File: rtl/bert_loopback.sv
module bert_loopback
  import bert_pkg::*;
#(
  parameter int SYM_W  = 8,
  parameter int LFSR_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_valid,
  input  logic [SYM_W-1:0] rx_data,
  input  logic             rx_ctrl,
  input  logic             rx_err,
  output logic             tx_valid,
  output logic [SYM_W-1:0] tx_data,
  output logic             tx_ctrl
);
  localparam int CNT_W = SYM_W;

  logic             reload, clear, query, slot, armed;
  logic             data_sym, hit;
  logic [SYM_W-1:0] key;
  logic [CNT_W-1:0] err_cnt;

  bert_os_detect #(.SYM_W(SYM_W)) u_det (
    .clk(clk), .rst(rst), .valid(rx_valid), .data(rx_data), .ctrl(rx_ctrl),
    .reload(reload), .clear(clear), .query(query), .slot(slot), .armed(armed)
  );

  assign data_sym = rx_valid && !rx_ctrl && !slot;
  assign hit      = armed && data_sym && (((rx_data ^ key) != '0) || rx_err);

  bert_descrambler #(.LFSR_W(LFSR_W), .SYM_W(SYM_W)) u_dsc (
    .clk(clk), .rst(rst), .reload(reload), .advance(data_sym), .key(key)
  );

  bert_err_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .clear(clear), .hit(hit), .count(err_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_valid <= 1'b0;
      tx_data  <= '0;
      tx_ctrl  <= 1'b0;
    end else begin
      tx_valid <= rx_valid;
      if (rx_valid) begin
        if (slot) begin
          tx_data <= err_cnt;
          tx_ctrl <= 1'b0;
        end else begin
          tx_data <= rx_data;
          tx_ctrl <= rx_ctrl;
        end
      end
    end
  end
endmodule

// File: rtl/bert_loopback_chk.sv
module bert_loopback_chk
  import bert_pkg::*;
#(
  parameter int SYM_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             rx_valid,
  input logic [SYM_W-1:0] rx_data,
  input logic             rx_ctrl,
  input logic             tx_valid,
  input logic [SYM_W-1:0] tx_data,
  input logic             tx_ctrl,
  input logic             slot,
  input logic             clear,
  input logic [SYM_W-1:0] err_cnt
);
  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> tx_valid);
  // R2
  echo_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && !slot) |=> (tx_data == $past(rx_data) && tx_ctrl == $past(rx_ctrl)));
  // R10
  idle_follow_chk: assert property (@(posedge clk) disable iff (rst)
    !rx_valid |=> !tx_valid);
  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rx_valid |=> $stable(err_cnt));
  // R8
  query_echo_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && !slot && rx_ctrl && rx_data == SYM_W'(K_QUERY)) |=> (tx_ctrl && tx_data == SYM_W'(K_QUERY)));
  // R8
  report_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && slot) |=> (!tx_ctrl && tx_data == $past(err_cnt)));
  // R3
  clear_chk: assert property (@(posedge clk) disable iff (rst)
    clear |=> (err_cnt == '0));
  // R5
  step_chk: assert property (@(posedge clk) disable iff (rst)
    !clear |=> (err_cnt == $past(err_cnt) || err_cnt == $past(err_cnt) + 1));
  // R7
  no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (err_cnt == '1 && !clear) |=> (err_cnt == '1));
endmodule

bind bert_loopback bert_loopback_chk #(.SYM_W(SYM_W)) u_chk (
  .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data), .rx_ctrl(rx_ctrl),
  .tx_valid(tx_valid), .tx_data(tx_data), .tx_ctrl(tx_ctrl),
  .slot(slot), .clear(clear), .err_cnt(err_cnt)
);

// File: tb/bert_loopback_test.sv
`timescale 1ns/1ps
module bert_loopback_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic       rx_ctrl = 1'b0;
  logic       rx_err = 1'b0;
  logic       tx_valid;
  logic [7:0] tx_data;
  logic       tx_ctrl;

  int n_tests = 0;
  int n_fail  = 0;

  logic [15:0] m_lfsr = 16'hFFFF;
  int          m_cnt  = 0;
  bit          m_armed = 1'b0;
  bit          m_prev  = 1'b0;

  always #2 clk = ~clk;

  bert_loopback uut (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data), .rx_ctrl(rx_ctrl),
    .rx_err(rx_err), .tx_valid(tx_valid), .tx_data(tx_data), .tx_ctrl(tx_ctrl)
  );

  function automatic logic [7:0] key_of(input logic [15:0] s0);
    logic [15:0] s = s0;
    logic [7:0]  k;
    for (int i = 0; i < 8; i++) begin
      k[i] = s[15];
      s = {s[14:0], 1'b0} ^ (s[15] ? 16'h0039 : 16'h0000);
    end
    return k;
  endfunction

  function automatic logic [15:0] step_of(input logic [15:0] s0);
    logic [15:0] s = s0;
    for (int i = 0; i < 8; i++) s = {s[14:0], 1'b0} ^ (s[15] ? 16'h0039 : 16'h0000);
    return s;
  endfunction

  task automatic chk(input string req, input int got, input int exp);
    n_tests++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic finish_up();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  // drive at a falling edge, observe one cycle later at the next falling edge
  task automatic sym(input logic [7:0] d, input logic k, input logic e, input string req);
    rx_valid = 1'b1; rx_data = d; rx_ctrl = k; rx_err = e;
    @(negedge clk);
    chk(req, tx_valid, 1);
  endtask

  task automatic send_ctrl(input logic [7:0] d, input string req);
    sym(d, 1'b1, 1'b0, req);
    chk(req, tx_data, d);
    chk(req, tx_ctrl, 1);
    if (d == 8'hBC) m_lfsr = 16'hFFFF;
    if (d == 8'hFC && m_prev) begin m_cnt = 0; m_armed = 1'b1; end
    m_prev = (d == 8'hBC);
  endtask

  task automatic send_data(input logic [7:0] mask, input logic e, input string req);
    logic [7:0] d;
    d = key_of(m_lfsr) ^ mask;
    sym(d, 1'b0, e, req);
    chk(req, tx_data, d);
    chk(req, tx_ctrl, 0);
    m_lfsr = step_of(m_lfsr);
    if (m_armed && (mask != 8'h00 || e) && m_cnt < 255) m_cnt++;
    m_prev = 1'b0;
  endtask

  task automatic clear_pair(input string req);
    send_ctrl(8'hBC, req);
    send_ctrl(8'hFC, req);
  endtask

  task automatic request(input string req, input logic [7:0] slot_d, input logic slot_k);
    sym(8'h7C, 1'b1, 1'b0, req);
    chk(req, tx_data, 8'h7C);
    chk(req, tx_ctrl, 1);
    sym(slot_d, slot_k, 1'b1, req);
    chk(req, tx_data, m_cnt);
    chk(req, tx_ctrl, 0);
    m_prev = 1'b0;
  endtask

  task automatic idle(input int n, input string req);
    rx_valid = 1'b0; rx_data = 8'h5A; rx_ctrl = 1'b0; rx_err = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(req, tx_valid, 0);
    end
  endtask

  initial begin
    #(4 * 150000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 tx_valid", tx_valid, 0);
    chk("R1 tx_data", tx_data, 0);
    chk("R1 tx_ctrl", tx_ctrl, 0);
    rst = 1'b0;
    idle(2, "R1 idle");
    request("R1 total after reset", 8'h7C, 1'b1);

    // R6: counting disabled before any clear pair
    for (int i = 0; i < 5; i++) send_data(8'hFF, 1'b1, "R6 unarmed");
    request("R6 report", 8'h7C, 1'b1);

    // R3 / R4: clear pair, then matching keystream gives no errors
    clear_pair("R3 clear pair");
    for (int i = 0; i < 16; i++) send_data(8'h00, 1'b0, "R4 clean");
    request("R4 clean report", 8'h7C, 1'b1);

    // R5: value mismatches and decode-error flags
    for (int v = 1; v <= 40; v++) send_data(8'(v), 1'b0, "R5 mismatch");
    request("R5 mismatch report", 8'h7C, 1'b1);
    for (int i = 0; i < 5; i++) send_data(8'h00, 1'b1, "R9 resume flag");
    request("R9 resumed report", 8'h7C, 1'b1);

    // R11: control symbols do not advance keystream
    send_data(8'h00, 1'b0, "R11 pre");
    send_ctrl(8'h1C, "R11 ctrl echo");
    send_ctrl(8'hF7, "R11 ctrl echo");
    for (int i = 0; i < 8; i++) send_data(8'h00, 1'b0, "R11 post");
    request("R11 report", 8'h7C, 1'b1);

    // R10: idle gaps change nothing
    idle(6, "R10 idle");
    for (int i = 0; i < 3; i++) send_data(8'h00, 1'b0, "R10 post");
    request("R10 report", 8'h7C, 1'b1);

    // R8: repeating request, and a data symbol in the report slot
    request("R8 rep1", 8'h7C, 1'b1);
    request("R8 rep2", 8'h7C, 1'b1);
    request("R8 rep3", 8'h7C, 1'b1);
    request("R8 data in slot", 8'hAA, 1'b0);
    for (int i = 0; i < 6; i++) send_data(8'h00, 1'b0, "R8 slot not counted");
    request("R8 after slot", 8'h7C, 1'b1);

    // R3 negative: lone second symbol does not clear
    send_ctrl(8'hFC, "R3 lone FC");
    request("R3 no clear", 8'h7C, 1'b1);

    // R4: lone reload reseeds without clearing
    send_data(8'h00, 1'b0, "R4 pre reseed");
    send_ctrl(8'hBC, "R4 reseed");
    for (int i = 0; i < 4; i++) send_data(8'h00, 1'b0, "R4 reseeded");
    request("R4 reseed report", 8'h7C, 1'b1);

    // R7: saturation
    clear_pair("R7 clear");
    for (int v = 0; v < 300; v++) send_data(8'((v % 255) + 1), 1'b0, "R7 burst");
    request("R7 saturated", 8'h7C, 1'b1);
    send_data(8'h01, 1'b0, "R7 beyond");
    request("R7 still saturated", 8'h7C, 1'b1);

    // R3 clear after saturation, R5 full mask sweep lands on 255
    clear_pair("R3 reclear");
    request("R3 cleared", 8'h7C, 1'b1);
    for (int v = 0; v < 256; v++) send_data(8'(v), 1'b0, "R5 sweep");
    request("R5 sweep report", 8'h7C, 1'b1);
    chk("R7 sweep total", m_cnt, 255);

    idle(2, "R10 tail");
    finish_up();
  end
endmodule